// File: doc/BRIEF.md
# Single-Slope Conversion Sequencer

This block runs a single-slope analog-to-digital conversion and uses a fine time-to-digital converter as its time base. It drives one digital ramp-control line. An external RC network turns the edges on that line into a reference ramp, and each conversion cycle holds two ramps: one rising and one falling. A comparator watches the reference against the analog input, and a separate TDC channel timestamps the moment the reference crosses the input. The block receives that timestamp as `xing_stamp` with the strobe `xing_vld`. The free-running fine time count arrives on `tdc_now`.

Each ramp has three stages:

1. The block waits out a quiet reset interval and does not sample during it.
2. It toggles the control line to launch the ramp and records the fine time of that launch.
3. It keeps the first crossing reported while the ramp runs.

When the ramp ends, the block subtracts the launch time from the crossing time and shifts the difference down to an N-bit code. It then corrects the code through a per-code calibration table, because the ramp need not be linear. The result is a registered sample with a one-cycle valid strobe, a bit giving the ramp direction and an overflow flag.

The ramp length, the reset-interval length, the scaling shift and the output width are parameters. Elaboration rejects any configuration whose ramp spans fewer than 2^N output codes.

Top module: `ss_conv_seq`

## Requirements
- R1: While `rst_n` is low and immediately after it rises, `ramp_ctl` is 0 and `sample_vld` is 0. The first interval after reset is a reset interval, and the first ramp launched is a rising ramp (`ramp_ctl` goes to 1).
- R2: `ramp_ctl` changes exactly once per period of `RST_CYC + RAMP_CYC` clock cycles, at the edge that launches a ramp, and alternates between 1 (rising ramp) and 0 (falling ramp). It holds its level for every other cycle of the ramp and of the reset interval.
- R3: The start time of a ramp is the value of `tdc_now` at the edge where `ramp_ctl` changes. The raw code is `((xing_stamp - start) mod 2^TW) >> SCALE_SH`.
- R4: The crossing used is the first one with `xing_vld` high during the `RAMP_CYC` edges of the ramp that follow the launch edge. Later crossings in the same ramp are ignored. Crossings in the reset interval, including the launch edge itself, are ignored.
- R5: If no crossing is taken during the ramp, or the raw code is 2^N or more, the sample code is all ones and `sample_ovf` is 1, and the calibration table is bypassed. Otherwise `sample_ovf` is 0.
- R6: `sample_vld` is high for exactly one cycle per ramp, `RAMP_CYC` edges after the launch edge, and is low in every other cycle.
- R7: `sample_dir` is 0 for a sample taken on a rising ramp and 1 for a sample taken on a falling ramp.
- R8: The calibration table holds one N-bit entry per raw code and resets to the identity mapping. A clock edge with `cal_we` high writes `cal_data` into entry `cal_addr`. A sample that is not an overflow carries the table entry for its raw code.
- R9: Elaboration fails when `(RAMP_CYC * FINE_PER_CLK) >> SCALE_SH` is below 2^N or when `TW` is not larger than N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tdc_now | input | TW | Current fine time count |
| xing_vld | input | 1 | Comparator crossing reported this cycle |
| xing_stamp | input | TW | Fine timestamp of the reported crossing |
| cal_we | input | 1 | Calibration table write enable |
| cal_addr | input | NB | Raw code whose table entry is written |
| cal_data | input | NB | Corrected value written into the table |
| ramp_ctl | output | 1 | Ramp control line: 1 launches the rising ramp, 0 launches the falling ramp |
| sample_vld | output | 1 | One-cycle strobe marking a new sample |
| sample_code | output | NB | Corrected sample code |
| sample_dir | output | 1 | Ramp direction of the sample (0 rising, 1 falling) |
| sample_ovf | output | 1 | No crossing taken, or raw code out of range |

## Verification
The launch edge is the edge at which `ramp_ctl` changes. The start time is the `tdc_now` value present at that edge, so the bench latches `tdc_now` on every rising edge and reads the latched value at the falling edge where it first sees the new `ramp_ctl` level. Counting from the launch edge, each crossing is driven half a cycle before the ramp edge it targets. The sample is due exactly `RAMP_CYC` edges later, and the bench checks the sample, the direction bit and the overflow flag at the falling edge right after that edge. It also checks that `sample_vld` is low at every other falling edge of the ramp and at the next falling edge after the sample. The spacing between launches is measured in clock cycles and compared with `RST_CYC + RAMP_CYC`.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

    // Phase of the reference: quiet reset interval or running ramp
    typedef enum logic {
        PH_QUIET = 1'b0,
        PH_RAMP  = 1'b1
    } ssc_phase_e;

    // Ramp direction encoding used on sample_dir
    localparam logic DIR_UP   = 1'b0;
    localparam logic DIR_DOWN = 1'b1;

endpackage

// File: rtl/ssc_sequencer.sv
module ssc_sequencer
    import ssc_pkg::*;
#(
    parameter int RST_CYC  = 4,
    parameter int RAMP_CYC = 40,
    parameter int TW       = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] tdc_now,
    output logic          ramp_ctl,
    output logic          in_ramp,
    output logic          ramp_last,
    output logic          ramp_dir,
    output logic [TW-1:0] start_stamp
);

    localparam int CNT_MAX = (RST_CYC > RAMP_CYC) ? RST_CYC : RAMP_CYC;
    localparam int CW      = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1;
    localparam logic [CW-1:0] QUIET_END = CW'(RST_CYC - 1);
    localparam logic [CW-1:0] RAMP_END  = CW'(RAMP_CYC - 1);

    typedef struct packed {
        ssc_phase_e    phase;
        logic          dir;
        logic [CW-1:0] cnt;
        logic          ctl;
        logic [TW-1:0] start;
    } seq_state_t;

    seq_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (s_q.phase)
            PH_QUIET: begin
                if (s_q.cnt == QUIET_END) begin
                    s_d.phase = PH_RAMP;
                    s_d.cnt   = '0;
                    s_d.ctl   = (s_q.dir == DIR_UP);
                    s_d.start = tdc_now;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: begin
                if (s_q.cnt == RAMP_END) begin
                    s_d.phase = PH_QUIET;
                    s_d.cnt   = '0;
                    s_d.dir   = ~s_q.dir;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.phase <= PH_QUIET;
            s_q.dir   <= DIR_UP;
            s_q.cnt   <= '0;
            s_q.ctl   <= 1'b0;
            s_q.start <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ramp_ctl    = s_q.ctl;
    assign in_ramp     = (s_q.phase == PH_RAMP);
    assign ramp_last   = in_ramp && (s_q.cnt == RAMP_END);
    assign ramp_dir    = s_q.dir;
    assign start_stamp = s_q.start;

    // R2
    ctl_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ramp_ctl) |-> (in_ramp && s_q.cnt == '0));

    // R2
    ctl_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ramp && s_q.cnt == '0 && !$stable(ramp_ctl)) |-> (ramp_ctl == (ramp_dir == DIR_UP)));

endmodule

// File: rtl/ssc_capture.sv
module ssc_capture #(
    parameter int NB       = 6,
    parameter int TW       = 16,
    parameter int SCALE_SH = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_ramp,
    input  logic          ramp_last,
    input  logic [TW-1:0] start_stamp,
    input  logic          xing_vld,
    input  logic [TW-1:0] xing_stamp,
    output logic [NB-1:0] res_code,
    output logic          res_ovf
);

    typedef struct packed {
        logic          got;
        logic          big;
        logic [NB-1:0] code;
    } cap_state_t;

    cap_state_t c_d, c_q;

    logic [TW-1:0] diff;
    logic [TW-1:0] scaled;
    logic          take;
    logic          big_now;
    logic [NB-1:0] code_now;
    logic          hit;

    always_comb begin
        diff     = xing_stamp - start_stamp;
        scaled   = diff >> SCALE_SH;
        big_now  = |scaled[TW-1:NB];
        code_now = scaled[NB-1:0];
        take     = in_ramp && xing_vld && !c_q.got;

        c_d = c_q;
        if (take) begin
            c_d.got  = 1'b1;
            c_d.big  = big_now;
            c_d.code = code_now;
        end
        if (ramp_last) begin
            c_d.got = 1'b0;
        end

        hit      = c_q.got || take;
        res_code = c_q.got ? c_q.code : code_now;
        res_ovf  = !hit || (c_q.got ? c_q.big : big_now);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    // R4
    hit_in_ramp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(c_q.got) |-> $past(in_ramp && xing_vld));

    // R4
    hit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.got && !ramp_last) |=> $stable(c_q.code));

endmodule

// File: rtl/ssc_cal_table.sv
module ssc_cal_table #(
    parameter int NB     = 6,
    parameter bit CAL_EN = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [NB-1:0] wr_addr,
    input  logic [NB-1:0] wr_data,
    input  logic [NB-1:0] rd_addr,
    output logic [NB-1:0] rd_data
);

    localparam int DEPTH = 1 << NB;

    generate
        if (CAL_EN) begin : g_table
            logic [NB-1:0] tbl_d [DEPTH];
            logic [NB-1:0] tbl_q [DEPTH];

            always_comb begin
                tbl_d = tbl_q;
                if (wr_en) begin
                    tbl_d[wr_addr] = wr_data;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) begin
                        tbl_q[i] <= NB'(i);
                    end
                end else begin
                    tbl_q <= tbl_d;
                end
            end

            assign rd_data = tbl_q[rd_addr];

            // R8
            tbl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
                wr_en |=> (tbl_q[$past(wr_addr)] == $past(wr_data)));
        end else begin : g_bypass
            logic unused_cal;
            assign unused_cal = &{1'b0, clk, rst_n, wr_en, wr_addr, wr_data};
            assign rd_data    = rd_addr;
        end
    endgenerate

endmodule

// File: rtl/ss_conv_seq.sv
module ss_conv_seq #(
    parameter int NB           = 6,
    parameter int TW           = 16,
    parameter int FINE_PER_CLK = 4,
    parameter int RAMP_CYC     = 40,
    parameter int RST_CYC      = 4,
    parameter int SCALE_SH     = 1,
    parameter bit CAL_EN       = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] tdc_now,
    input  logic          xing_vld,
    input  logic [TW-1:0] xing_stamp,
    input  logic          cal_we,
    input  logic [NB-1:0] cal_addr,
    input  logic [NB-1:0] cal_data,
    output logic          ramp_ctl,
    output logic          sample_vld,
    output logic [NB-1:0] sample_code,
    output logic          sample_dir,
    output logic          sample_ovf
);

    localparam longint RAMP_FINE = longint'(RAMP_CYC) * longint'(FINE_PER_CLK);
    localparam longint CODE_SPAN = longint'(1) << NB;
    localparam bit     CFG_OK    = ((RAMP_FINE >> SCALE_SH) >= CODE_SPAN) && (TW > NB)
                                   && (RAMP_CYC >= 2) && (RST_CYC >= 1);

    // R9
    generate
        if (!CFG_OK) begin : g_cfg_bad
            initial $fatal(1, "ss_conv_seq: ramp shorter than the output code range");
        end
    endgenerate

    typedef struct packed {
        logic          vld;
        logic [NB-1:0] code;
        logic          dir;
        logic          ovf;
    } out_state_t;

    out_state_t o_d, o_q;

    logic          in_ramp;
    logic          ramp_last;
    logic          ramp_dir;
    logic [TW-1:0] start_stamp;
    logic [NB-1:0] res_code;
    logic          res_ovf;
    logic [NB-1:0] cal_code;

    ssc_sequencer #(
        .RST_CYC  (RST_CYC),
        .RAMP_CYC (RAMP_CYC),
        .TW       (TW)
    ) i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .tdc_now     (tdc_now),
        .ramp_ctl    (ramp_ctl),
        .in_ramp     (in_ramp),
        .ramp_last   (ramp_last),
        .ramp_dir    (ramp_dir),
        .start_stamp (start_stamp)
    );

    ssc_capture #(
        .NB       (NB),
        .TW       (TW),
        .SCALE_SH (SCALE_SH)
    ) i_cap (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_ramp     (in_ramp),
        .ramp_last   (ramp_last),
        .start_stamp (start_stamp),
        .xing_vld    (xing_vld),
        .xing_stamp  (xing_stamp),
        .res_code    (res_code),
        .res_ovf     (res_ovf)
    );

    ssc_cal_table #(
        .NB     (NB),
        .CAL_EN (CAL_EN)
    ) i_cal (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cal_we),
        .wr_addr (cal_addr),
        .wr_data (cal_data),
        .rd_addr (res_code),
        .rd_data (cal_code)
    );

    always_comb begin
        o_d     = o_q;
        o_d.vld = ramp_last;
        if (ramp_last) begin
            o_d.code = res_ovf ? {NB{1'b1}} : cal_code;
            o_d.dir  = ramp_dir;
            o_d.ovf  = res_ovf;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign sample_vld  = o_q.vld;
    assign sample_code = o_q.code;
    assign sample_dir  = o_q.dir;
    assign sample_ovf  = o_q.ovf;

    // R6
    vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld |=> !sample_vld);

    // R6
    vld_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld |-> $past(ramp_last));

    // R5
    ovf_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld && sample_ovf) |-> (sample_code == {NB{1'b1}}));

    // R7
    dir_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld |-> (sample_dir != ramp_ctl));

endmodule

// File: tb/test_ss_conv_seq.sv
module test_ss_conv_seq;

    localparam int NB    = 4;
    localparam int TW    = 12;
    localparam int FPC   = 8;
    localparam int RAMP  = 4;
    localparam int QUIET = 3;
    localparam int SH    = 1;
    localparam int SPAN  = 1 << NB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] tdc_now = '0;
    logic          xing_vld = 1'b0;
    logic [TW-1:0] xing_stamp = '0;
    logic          cal_we = 1'b0;
    logic [NB-1:0] cal_addr = '0;
    logic [NB-1:0] cal_data = '0;
    logic          ramp_ctl;
    logic          sample_vld;
    logic [NB-1:0] sample_code;
    logic          sample_dir;
    logic          sample_ovf;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int last_start_cyc = 0;
    bit have_prev = 1'b0;
    bit first_ramp = 1'b1;
    logic [TW-1:0] s_edge = '0;
    logic [NB-1:0] cal_model [SPAN];

    ss_conv_seq #(
        .NB           (NB),
        .TW           (TW),
        .FINE_PER_CLK (FPC),
        .RAMP_CYC     (RAMP),
        .RST_CYC      (QUIET),
        .SCALE_SH     (SH),
        .CAL_EN       (1'b1)
    ) i_ss_conv_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .tdc_now     (tdc_now),
        .xing_vld    (xing_vld),
        .xing_stamp  (xing_stamp),
        .cal_we      (cal_we),
        .cal_addr    (cal_addr),
        .cal_data    (cal_data),
        .ramp_ctl    (ramp_ctl),
        .sample_vld  (sample_vld),
        .sample_code (sample_code),
        .sample_dir  (sample_dir),
        .sample_ovf  (sample_ovf)
    );

    always #10 clk = ~clk;

    always @(negedge clk) tdc_now <= tdc_now + TW'(FPC);
    always @(posedge clk) s_edge <= tdc_now;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Wait for the launch edge; optionally report crossings throughout the quiet interval
    task automatic wait_launch(input bit quiet_hits, output logic [TW-1:0] start, output logic lvl);
        logic prev;
        prev = ramp_ctl;
        forever begin
            xing_vld   = quiet_hits;
            xing_stamp = tdc_now;
            @(negedge clk);
            if (ramp_ctl != prev) break;
        end
        xing_vld = 1'b0;
        start    = s_edge;
        lvl      = ramp_ctl;
    endtask

    // One ramp: crossing k1 at offset d1, optional later crossing k2 at offset d2 (k=0: none)
    task automatic run_ramp(input int k1, input int d1, input int k2, input int d2, input bit quiet_hits);
        logic [TW-1:0] start;
        logic          lvl;
        int            raw;
        int            exp_code;
        bit            exp_ovf;
        bit            exp_dir;
        wait_launch(quiet_hits, start, lvl);
        if (first_ramp) begin
            // R1 first ramp after reset is rising
            chk(lvl == 1'b1, "R1 first ramp level", int'(lvl), 1);
            first_ramp = 1'b0;
        end
        if (have_prev) begin
            // R2 launch spacing
            chk(cyc - last_start_cyc == RAMP + QUIET, "R2 launch period", cyc - last_start_cyc, RAMP + QUIET);
        end
        have_prev      = 1'b1;
        last_start_cyc = cyc;
        exp_dir        = (lvl == 1'b1) ? 1'b0 : 1'b1;
        for (int j = 1; j <= RAMP; j++) begin
            xing_vld   = (j == k1) || (j == k2);
            xing_stamp = start + TW'((j == k1) ? d1 : d2);
            chk(sample_vld == 1'b0, "R6 no strobe mid ramp", int'(sample_vld), 0);
            @(negedge clk);
            // R2 level held through the ramp
            chk(ramp_ctl == lvl, "R2 level held", int'(ramp_ctl), int'(lvl));
        end
        xing_vld = 1'b0;
        if (k1 == 0) begin
            exp_ovf  = 1'b1;
            exp_code = SPAN - 1;
        end else begin
            raw = d1 >> SH;
            exp_ovf  = (raw >= SPAN);
            exp_code = exp_ovf ? SPAN - 1 : int'(cal_model[raw]);
        end
        chk(sample_vld == 1'b1, "R6 strobe at ramp end", int'(sample_vld), 1);
        chk(int'(sample_code) == exp_code, "R3/R4/R8 sample code", int'(sample_code), exp_code);
        chk(sample_ovf == exp_ovf, "R5 overflow flag", int'(sample_ovf), int'(exp_ovf));
        chk(sample_dir == exp_dir, "R7 direction bit", int'(sample_dir), int'(exp_dir));
        xing_vld   = quiet_hits;
        xing_stamp = tdc_now;
        @(negedge clk);
        chk(sample_vld == 1'b0, "R6 strobe one cycle", int'(sample_vld), 0);
    endtask

    task automatic resync();
        while (!sample_vld) @(negedge clk);
        have_prev = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual 0 expected 1 (run completed)");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < SPAN; i++) cal_model[i] = NB'(i);
        repeat (3) @(negedge clk);
        // R1 state under reset
        chk(ramp_ctl == 1'b0, "R1 ramp_ctl in reset", int'(ramp_ctl), 0);
        chk(sample_vld == 1'b0, "R1 sample_vld in reset", int'(sample_vld), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ramp_ctl == 1'b0, "R1 ramp_ctl after reset", int'(ramp_ctl), 0);
        chk(sample_vld == 1'b0, "R1 sample_vld after reset", int'(sample_vld), 0);

        // R3 R5 sweep with identity table, crossing position rotating over the ramp
        for (int d = 0; d <= 2 * SPAN + 6; d++) begin
            run_ramp((d % RAMP) + 1, d, 0, 0, 1'b0);
        end
        // R5 no crossing at all
        run_ramp(0, 0, 0, 0, 1'b0);
        run_ramp(0, 0, 0, 0, 1'b0);
        // R4 crossings only in the quiet interval before the ramp are ignored
        run_ramp(0, 0, 0, 0, 1'b1);
        run_ramp(2, 10, 0, 0, 1'b1);
        // R4 first crossing wins over a later one
        run_ramp(1, 6, 3, 20, 1'b0);
        run_ramp(2, 27, 4, 2, 1'b0);
        // R3 crossing on the last ramp edge, and a far offset that wraps past full scale
        run_ramp(RAMP, 31, 0, 0, 1'b0);
        run_ramp(RAMP, (1 << TW) - 2, 0, 0, 1'b0);

        // R8 load a scrambled calibration table
        for (int i = 0; i < SPAN; i++) begin
            cal_we   = 1'b1;
            cal_addr = NB'(i);
            cal_data = NB'((i * 7 + 5) % SPAN);
            cal_model[i] = NB'((i * 7 + 5) % SPAN);
            @(negedge clk);
        end
        cal_we = 1'b0;
        resync();

        // R8 sweep through the corrected table, both ramp directions
        for (int d = 0; d <= 2 * SPAN + 6; d++) begin
            run_ramp(((d + 1) % RAMP) + 1, d, 0, 0, 1'b0);
        end
        // R5 overflow bypasses the table
        run_ramp(0, 0, 0, 0, 1'b0);
        run_ramp(1, 2 * SPAN, 0, 0, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule